// File: doc/BRIEF.md
# Raster Video Address Generator

This block produces the memory address for each 16-bit word that a bitplane raster display fetches. A byte-wide register port gives software a frame base address, a live address counter, a per-line skip measured in words and a 4-bit horizontal pixel offset. Three timing strobes drive it: `line_active` marks the visible part of a line, `line_end` closes the line and `frame_start` opens a new frame.

During an active line the block raises `fetch_req` and presents the counter on `fetch_addr`. The counter then steps by one word. Each line fetches a fixed quota of words, and after that the request drops even if `line_active` stays high. A nonzero pixel offset raises the quota by one extra group of words. At `line_end` the counter jumps ahead by the skip value. At `frame_start` it reloads from the base register.

The base register only sets the starting point of the next frame. Software that needs an immediate change writes the counter instead. Writing the base high or mid byte clears the base low byte, so the low byte has to be written last.

Top module: `raster_addr_gen`

## Requirements
- R1: Base and counter are 22-bit byte addresses held as three byte registers. The high byte (bus addresses 0 and 3) holds bits 21:16, and bits 7:6 read as 0. The mid byte (addresses 1 and 4) holds bits 15:8. The low byte (addresses 2 and 5) holds bits 7:0, and bit 0 always reads as 0. Every register resets to 0.
- R2: A write to the base high byte (address 0) or the base mid byte (address 1) also sets the base low byte to 0.
- R3: A base write leaves the counter unchanged. At `frame_start` the counter takes the base value.
- R4: The counter bytes (addresses 3, 4, 5) can be read and written. A counter write is seen on `fetch_addr` in the next cycle. When a counter write coincides with a fetch step, frame reload or line skip, the written value wins.
- R5: When `fetch_req` is high, `fetch_addr` equals the counter, and the counter advances by 2 bytes (one word) for the next cycle.
- R6: `fetch_req` is high only while `line_active` is high, `line_end` and `frame_start` are low, and fewer words than the line quota have been fetched since the last `line_end` or `frame_start`. The quota is 80 words when the pixel offset (address 7, bits 3:0) is 0, and 84 words otherwise.
- R7: At `line_end` (without `frame_start`), the counter advances by twice the line skip (address 6, in words).
- R8: Counter arithmetic wraps modulo 2^22.
- R9: Address 7 reads back only bits 3:0. Addresses 8 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| frame_start | input | 1 | Frame begins; reload counter from base |
| line_active | input | 1 | Visible portion of a line |
| line_end | input | 1 | Line finished; apply skip |
| fetch_req | output | 1 | Fetch one word this cycle |
| fetch_addr | output | 22 | Byte address of the word to fetch |

## Verification
Directed lines run with a zero pixel offset and then a nonzero one, with `line_active` held high longer than the quota. This separates the 80-word and 84-word quotas and shows that the request stops on its own. Byte writes in high, mid, low order are compared with low-first order to expose the clearing of the low byte. Reads before and after `frame_start` separate base storage from the live counter. A counter write landing in a fetch cycle, and a counter placed just below 2^22, test the write priority and the wrap. A long run with a fixed seed then mixes random register writes with random strobe patterns, including `line_end` and `frame_start` arriving mid-line or together, and checks every cycle against a reference model.

// File: rtl/raster_addr_pkg.sv
package raster_addr_pkg;

  typedef enum logic [3:0] {
    RA_BASE_HI  = 4'd0,
    RA_BASE_MID = 4'd1,
    RA_BASE_LO  = 4'd2,
    RA_CTR_HI   = 4'd3,
    RA_CTR_MID  = 4'd4,
    RA_CTR_LO   = 4'd5,
    RA_SKIP     = 4'd6,
    RA_PIX      = 4'd7
  } ra_reg_e;

  // Valid address bits for a width of aw, with bit 0 always clear
  function automatic logic [31:0] addr_mask(int unsigned aw);
    return ((32'h1 << aw) - 32'h1) & ~32'h1;
  endfunction

  // Advance a byte address by a count of 16-bit words, wrapping
  function automatic logic [31:0] step_words(logic [31:0] a, logic [31:0] words,
                                             int unsigned aw);
    return (a + (words << 1)) & addr_mask(aw);
  endfunction

  // Replace byte idx (0 = low) of an address, keeping it in range
  function automatic logic [31:0] put_byte(logic [31:0] a, int unsigned idx,
                                           logic [7:0] d, int unsigned aw);
    logic [31:0] m;
    m = 32'hFF << (8 * idx);
    return ((a & ~m) | (32'(d) << (8 * idx))) & addr_mask(aw);
  endfunction

  function automatic logic [7:0] get_byte(logic [31:0] a, int unsigned idx);
    return 8'(a >> (8 * idx));
  endfunction

  // Words fetched per line: one extra group when a pixel offset is set
  function automatic int unsigned line_quota(logic [3:0] pix, int unsigned line_words,
                                             int unsigned group_words);
    return line_words + ((pix != 4'd0) ? group_words : 0);
  endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned SKIP_W = 8,
  parameter int unsigned PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [ADDR_W-1:0] ctr_q,
  output logic [7:0]        bus_rdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [SKIP_W-1:0] skip_q,
  output logic [PIX_W-1:0]  pix_q,
  output logic              ctr_wr,
  output logic [ADDR_W-1:0] ctr_wr_val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      skip_q <= '0;
      pix_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        RA_BASE_HI:  base_q <= ADDR_W'(put_byte(put_byte(32'(base_q), 2, bus_wdata, ADDR_W),
                                                0, 8'h00, ADDR_W));
        RA_BASE_MID: base_q <= ADDR_W'(put_byte(put_byte(32'(base_q), 1, bus_wdata, ADDR_W),
                                                0, 8'h00, ADDR_W));
        RA_BASE_LO:  base_q <= ADDR_W'(put_byte(32'(base_q), 0, bus_wdata, ADDR_W));
        RA_SKIP:     skip_q <= SKIP_W'(bus_wdata);
        RA_PIX:      pix_q  <= PIX_W'(bus_wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    ctr_wr     = 1'b0;
    ctr_wr_val = ctr_q;
    if (bus_we) begin
      case (bus_addr)
        RA_CTR_HI: begin
          ctr_wr = 1'b1;
          ctr_wr_val = ADDR_W'(put_byte(32'(ctr_q), 2, bus_wdata, ADDR_W));
        end
        RA_CTR_MID: begin
          ctr_wr = 1'b1;
          ctr_wr_val = ADDR_W'(put_byte(32'(ctr_q), 1, bus_wdata, ADDR_W));
        end
        RA_CTR_LO: begin
          ctr_wr = 1'b1;
          ctr_wr_val = ADDR_W'(put_byte(32'(ctr_q), 0, bus_wdata, ADDR_W));
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      RA_BASE_HI:  bus_rdata = get_byte(32'(base_q), 2);
      RA_BASE_MID: bus_rdata = get_byte(32'(base_q), 1);
      RA_BASE_LO:  bus_rdata = get_byte(32'(base_q), 0);
      RA_CTR_HI:   bus_rdata = get_byte(32'(ctr_q), 2);
      RA_CTR_MID:  bus_rdata = get_byte(32'(ctr_q), 1);
      RA_CTR_LO:   bus_rdata = get_byte(32'(ctr_q), 0);
      RA_SKIP:     bus_rdata = 8'(skip_q);
      RA_PIX:      bus_rdata = 8'(pix_q);
      default:     bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/raster_counter.sv
module raster_counter
  import raster_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctr_wr,
  input  logic [ADDR_W-1:0] ctr_wr_val,
  input  logic              frame_start,
  input  logic              line_end,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [SKIP_W-1:0] skip_q,
  output logic [ADDR_W-1:0] ctr_q
);

  logic [ADDR_W-1:0] ctr_d;

  // Priority: bus write, frame reload, line skip, fetch step
  always_comb begin
    if (ctr_wr)           ctr_d = ctr_wr_val;
    else if (frame_start) ctr_d = base_q;
    else if (line_end)    ctr_d = ADDR_W'(step_words(32'(ctr_q), 32'(skip_q), ADDR_W));
    else if (fetch_req)   ctr_d = ADDR_W'(step_words(32'(ctr_q), 32'd1, ADDR_W));
    else                  ctr_d = ctr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

endmodule

// File: rtl/raster_line_ctl.sv
module raster_line_ctl
  import raster_addr_pkg::*;
#(
  parameter int unsigned LINE_WORDS  = 80,
  parameter int unsigned GROUP_WORDS = 4,
  parameter int unsigned PIX_W       = 4,
  localparam int unsigned CNT_W      = $clog2(LINE_WORDS + GROUP_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_active,
  input  logic             line_end,
  input  logic             frame_start,
  input  logic [PIX_W-1:0] pix_q,
  output logic             fetch_req,
  output logic [CNT_W-1:0] words_q,
  output logic [CNT_W-1:0] quota
);

  always_comb begin
    quota     = CNT_W'(line_quota(4'(pix_q), LINE_WORDS, GROUP_WORDS));
    fetch_req = line_active && !line_end && !frame_start && (words_q < quota);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        words_q <= '0;
    else if (frame_start || line_end)  words_q <= '0;
    else if (fetch_req)                words_q <= words_q + CNT_W'(1);
  end

endmodule

// File: rtl/raster_addr_gen.sv
module raster_addr_gen
  import raster_addr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned SKIP_W      = 8,
  parameter int unsigned PIX_W       = 4,
  parameter int unsigned LINE_WORDS  = 80,
  parameter int unsigned GROUP_WORDS = 4,
  localparam int unsigned CNT_W      = $clog2(LINE_WORDS + GROUP_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              frame_start,
  input  logic              line_active,
  input  logic              line_end,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ctr_q;
  logic [ADDR_W-1:0] ctr_wr_val;
  logic              ctr_wr;
  logic [SKIP_W-1:0] skip_q;
  logic [PIX_W-1:0]  pix_q;
  logic [CNT_W-1:0]  words_q;
  logic [CNT_W-1:0]  quota;

  raster_regs #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .PIX_W(PIX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctr_q(ctr_q), .bus_rdata(bus_rdata),
    .base_q(base_q), .skip_q(skip_q), .pix_q(pix_q),
    .ctr_wr(ctr_wr), .ctr_wr_val(ctr_wr_val)
  );

  raster_line_ctl #(.LINE_WORDS(LINE_WORDS), .GROUP_WORDS(GROUP_WORDS),
                    .PIX_W(PIX_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_active(line_active), .line_end(line_end),
    .frame_start(frame_start), .pix_q(pix_q), .fetch_req(fetch_req),
    .words_q(words_q), .quota(quota)
  );

  raster_counter #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ctr_wr(ctr_wr), .ctr_wr_val(ctr_wr_val),
    .frame_start(frame_start), .line_end(line_end), .fetch_req(fetch_req),
    .base_q(base_q), .skip_q(skip_q), .ctr_q(ctr_q)
  );

  assign fetch_addr = ctr_q;

endmodule

// File: rtl/raster_addr_chk.sv
module raster_addr_chk
  import raster_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned SKIP_W = 8,
  parameter int unsigned CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [3:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              frame_start,
  input logic              line_active,
  input logic              line_end,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ctr_wr,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] ctr_q,
  input logic [SKIP_W-1:0] skip_q,
  input logic [CNT_W-1:0]  words_q
);

  logic base_hm_wr;
  assign base_hm_wr = bus_we && (bus_addr == RA_BASE_HI || bus_addr == RA_BASE_MID);

  a_r2_low_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    base_hm_wr |=> base_q[7:0] == 8'h00);

  a_r3_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !ctr_wr |=> ctr_q == $past(base_q));

  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == RA_CTR_LO |=> ctr_q[7:0] == {$past(bus_wdata[7:1]), 1'b0});

  a_r5_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !ctr_wr |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(2)));

  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> line_active && !line_end && !frame_start);

  a_r6_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> words_q == '0);

  a_r7_skip: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !frame_start && !ctr_wr |=>
      ctr_q == ADDR_W'($past(ctr_q) + ADDR_W'({$past(skip_q), 1'b0})));

endmodule

bind raster_addr_gen raster_addr_chk #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .frame_start(frame_start), .line_active(line_active), .line_end(line_end),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .ctr_wr(ctr_wr), .base_q(base_q),
  .ctr_q(ctr_q), .skip_q(skip_q), .words_q(words_q)
);

// File: tb/raster_addr_gen_tb.sv
module raster_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        frame_start = 1'b0;
  logic        line_active = 1'b0;
  logic        line_end = 1'b0;
  logic        fetch_req;
  logic [21:0] fetch_addr;

  raster_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
    .line_active(line_active), .line_end(line_end), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr)
  );

  always #4 clk = ~clk;

  int unsigned checks = 0, failures = 0, n_fetch = 0;
  int unsigned m_base = 0, m_ctr = 0, m_skip = 0, m_pix = 0, m_words = 0;
  bit done = 0;

  localparam int unsigned AMOD = 32'h400000;

  function automatic int unsigned quota_of(int unsigned pix);
    return (pix == 0) ? 80 : 84;
  endfunction

  function automatic int unsigned exp_rd(int unsigned a);
    case (a)
      0: return (m_base >> 16) & 8'h3F;
      1: return (m_base >> 8) & 8'hFF;
      2: return m_base & 8'hFE;
      3: return (m_ctr >> 16) & 8'h3F;
      4: return (m_ctr >> 8) & 8'hFF;
      5: return m_ctr & 8'hFE;
      6: return m_skip;
      7: return m_pix;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned act,
                     input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare with model, then advance the model
  task automatic cycle(input bit we, input int unsigned a, input int unsigned d,
                       input bit act, input bit le, input bit fs);
    bit req;
    int unsigned nc;
    @(negedge clk);
    bus_we = we; bus_addr = 4'(a); bus_wdata = 8'(d);
    line_active = act; line_end = le; frame_start = fs;
    #1;
    req = act && !le && !fs && (m_words < quota_of(m_pix));
    chk(bus_rdata == 8'(exp_rd(a)), (a <= 2) ? "R1 base read" :
        (a <= 5) ? "R4 counter read" : "R9 reg read", bus_rdata, exp_rd(a));
    chk(fetch_req == req, "R6 fetch_req", fetch_req, req);
    if (req) begin
      chk(fetch_addr == 22'(m_ctr), "R5 fetch_addr", fetch_addr, m_ctr);
      n_fetch++;
    end
    nc = m_ctr;
    if (we && a == 3)      nc = (m_ctr & 32'h00FFFF) | ((d & 8'h3F) << 16);
    else if (we && a == 4) nc = (m_ctr & 32'h3F00FF) | (d << 8);
    else if (we && a == 5) nc = (m_ctr & 32'h3FFF00) | (d & 8'hFE);
    else if (fs)           nc = m_base;
    else if (le)           nc = (m_ctr + 2 * m_skip) % AMOD;
    else if (req)          nc = (m_ctr + 2) % AMOD;
    if (fs || le) m_words = 0; else if (req) m_words++;
    m_ctr = nc;
    if (we) begin
      case (a)
        0: m_base = (m_base & 32'h00FF00) | ((d & 8'h3F) << 16);
        1: m_base = (m_base & 32'h3F0000) | (d << 8);
        2: m_base = (m_base & 32'h3FFF00) | (d & 8'hFE);
        6: m_skip = d;
        7: m_pix = d & 8'h0F;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int unsigned a, input int unsigned d);
    cycle(1, a, d, 0, 0, 0);
  endtask

  task automatic rd(input int unsigned a, output int unsigned v);
    @(negedge clk);
    bus_we = 0; bus_addr = 4'(a); line_active = 0; line_end = 0; frame_start = 0;
    #1 v = bus_rdata;
  endtask

  task automatic rd_ctr(output int unsigned v);
    int unsigned h, m, l;
    rd(3, h); rd(4, m); rd(5, l);
    v = (h << 16) | (m << 8) | l;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1/R9 reset state across all sixteen addresses
    for (int i = 0; i < 16; i++) cycle(0, i, 0, 0, 0, 0);
    // R1 masking of high bits and bit 0
    wr(0, 8'hFF); rd(0, v); chk(v == 8'h3F, "R1 high mask", v, 8'h3F);
    wr(2, 8'h35); rd(2, v); chk(v == 8'h34, "R1 low bit0", v, 8'h34);
    // R2 mid and high writes clear the low byte
    wr(1, 8'h12); rd(2, v); chk(v == 0, "R2 mid clears low", v, 0);
    wr(2, 8'h41); wr(0, 8'h01); rd(2, v); chk(v == 0, "R2 high clears low", v, 0);
    // R9 writes to unused addresses are ignored
    wr(12, 8'hAA); rd(12, v); chk(v == 0, "R9 unused addr", v, 0);
    // R3 base 0x012340 does not touch counter until frame_start
    wr(0, 8'h01); wr(1, 8'h23); wr(2, 8'h40);
    rd_ctr(v); chk(v == 0, "R3 counter untouched", v, 0);
    cycle(0, 0, 0, 0, 0, 1);
    rd_ctr(v); chk(v == 32'h012340, "R3 frame reload", v, 32'h012340);
    // R6/R7 zero pixel offset: 80 fetches then skip of 8 words
    wr(6, 8); n_fetch = 0;
    for (int i = 0; i < 100; i++) cycle(0, 8, 0, 1, 0, 0);
    chk(n_fetch == 80, "R6 quota pix=0", n_fetch, 80);
    cycle(0, 8, 0, 0, 1, 0);
    rd_ctr(v); chk(v == 32'h0123F0, "R7 line skip", v, 32'h0123F0);
    // R6 nonzero pixel offset adds a group
    wr(7, 5); n_fetch = 0;
    for (int i = 0; i < 100; i++) cycle(0, 8, 0, 1, 0, 0);
    chk(n_fetch == 84, "R6 quota pix>0", n_fetch, 84);
    cycle(0, 8, 0, 0, 1, 0);
    rd_ctr(v); chk(v == 32'h0124A8, "R7 skip after extra group", v, 32'h0124A8);
    // R4 counter write beats a fetch in the same cycle
    cycle(1, 5, 8'h10, 1, 0, 0);
    rd(5, v); chk(v == 8'h10, "R4 write wins", v, 8'h10);
    cycle(0, 8, 0, 1, 0, 0);
    // R8 wrap at the top of the address space
    cycle(0, 8, 0, 0, 1, 0);
    wr(3, 8'h3F); wr(4, 8'hFF); wr(5, 8'hFE);
    cycle(0, 8, 0, 1, 0, 0);
    rd_ctr(v); chk(v == 0, "R8 wrap", v, 0);
    // Random mix checked every cycle against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 20000; i++) begin
      bit we, le, fs, act;
      we  = ($urandom % 8) == 0;
      le  = ($urandom % 60) == 0;
      fs  = ($urandom % 700) == 0;
      act = ($urandom % 10) != 0;
      cycle(we, $urandom % 16, $urandom % 256, act, le, fs);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule